// File: doc/BRIEF.md
# Symmetric Coarse/Fine Segment Decoder for a Stereo Current DAC

This block turns two 16-bit two's complement audio samples, one per stereo channel, into the switch controls of a segmented current-steering converter. Each channel gets three controls. The first is a 31-bit thermometer vector of coarse unit-current enables. The second is an 11-bit word for the binary divider that is fed by one further unit source. The third is a polarity bit that tells the summing stage whether the divider output adds to the coarse sum or is mirrored below it.

The mapping mirrors negative codes about the point between -1 and 0. A sign change around zero therefore moves only the divider word and the polarity bit. The coarse segments stay put, and the carry that causes crossover distortion never happens there.

Both channels register their controls on the same clock edge, when the load strobe is high. The converter therefore updates left and right together. The strobe is a plain control pin. The block accepts a sample pair on every strobe and never applies back-pressure. Between strobes the controls hold, whatever the sample pins do.

Top module: `seg_dac_decoder`

## Requirements
- R1: While reset is asserted, and after reset until the first load, each channel shows the decode of code 0: segment bits 15..0 set, bits 30..16 clear, divider word 0, polarity 0.
- R2: The segment vector is always in thermometer form. The set bits run without a gap upward from bit 0, and their number is the coarse count.
- R3: For a sample s with bit 15 clear, the coarse count is 16 + s[14:11], the divider word is s[10:0] and the polarity bit is 0.
- R4: For a sample s with bit 15 set, take m = ~s. The coarse count is 16 - m[14:11], the divider word is 2047 - m[10:0] and the polarity bit is 1.
- R5: The samples -1 (16'hFFFF) and 0 give identical segment vectors. Only the divider word and the polarity bit differ.
- R6: The extreme codes decode without wrap. 32767 sets all 31 segments with a divider word of 2047. -32768 sets only bit 0 with a divider word of 0.
- R7: A high load at a rising edge updates both channels at that same edge from their own sample inputs. The new values are visible after that edge.
- R8: With load low at a rising edge, all outputs of both channels keep their values, even when the sample inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Load strobe that captures both channels |
| smp_l | input | 16 | Left sample, two's complement |
| smp_r | input | 16 | Right sample, two's complement |
| seg_l | output | 31 | Left coarse segment enables, thermometer |
| div_l | output | 11 | Left binary divider word |
| neg_l | output | 1 | Left divider polarity (1 = mirrored below zero) |
| seg_r | output | 31 | Right coarse segment enables, thermometer |
| div_r | output | 11 | Right binary divider word |
| neg_r | output | 1 | Right divider polarity |

## Verification
All three controls of both channels sit one register away from the sample pins. A pair strobed at rising edge k is therefore due right after edge k and is compared at the falling edge that follows. On every other falling edge, the monitor compares the outputs against the last pair it popped, which covers the hold behaviour with one cycle of separation. The driver changes inputs 1 ns after a rising edge and pushes its expected values into the scoreboard as it raises the strobe. The monitor pops an entry only at the falling edge after it has seen the strobe high, so the expected data and the result stay aligned even with loads spaced two cycles apart.

// File: rtl/dac_seg_pkg.sv
package dac_seg_pkg;
  // Default sample width and number of coarse (upper) sample bits.
  localparam int DEF_SMP_W = 16;
  localparam int DEF_CRS_W = 5;

  // Coarse count that stands for the centre of the scale.
  function automatic int mid_count(input int crs_w);
    return 1 << (crs_w - 1);
  endfunction
endpackage

// File: rtl/seg_split.sv
// Splits one two's complement sample into coarse count, divider word and
// divider polarity, mirroring negative codes about the -1/0 boundary.
module seg_split #(
  parameter int SMP_W = 16,
  parameter int CRS_W = 5,
  localparam int FINE_W = SMP_W - CRS_W
) (
  input  logic [SMP_W-1:0]  smp,
  output logic [CRS_W-1:0]  cnt,
  output logic [FINE_W-1:0] fine,
  output logic              neg
);
  localparam int MAG_W = CRS_W - 1;
  localparam logic [CRS_W-1:0]  CNT_MID  = CRS_W'(1 << MAG_W);
  localparam logic [FINE_W-1:0] FINE_TOP = {FINE_W{1'b1}};

  logic [SMP_W-2:0] mir;      // one's complement of the magnitude bits
  logic [MAG_W-1:0] hi_pos;
  logic [MAG_W-1:0] hi_neg;

  assign neg    = smp[SMP_W-1];
  assign mir    = ~smp[SMP_W-2:0];
  assign hi_pos = smp[SMP_W-2:FINE_W];
  assign hi_neg = mir[SMP_W-2:FINE_W];

  always_comb begin
    if (neg) begin
      cnt  = CNT_MID - CRS_W'(hi_neg);
      fine = FINE_TOP - mir[FINE_W-1:0];
    end else begin
      cnt  = CNT_MID + CRS_W'(hi_pos);
      fine = smp[FINE_W-1:0];
    end
  end
endmodule

// File: rtl/seg_therm.sv
// Binary coarse count to thermometer enables, low bits set first.
module seg_therm #(
  parameter int CRS_W = 5,
  localparam int SEG_N = (1 << CRS_W) - 1
) (
  input  logic [CRS_W-1:0] cnt,
  output logic [SEG_N-1:0] seg
);
  for (genvar i = 0; i < SEG_N; i++) begin : g_seg
    assign seg[i] = ({1'b0, cnt} > (CRS_W+1)'(i));
  end
endmodule

// File: rtl/seg_dac_decoder.sv
// Stereo segment decoder: per-channel split and thermometer logic feeding
// output registers that all load on the same strobe edge.
module seg_dac_decoder
  import dac_seg_pkg::*;
#(
  parameter int SMP_W = DEF_SMP_W,
  parameter int CRS_W = DEF_CRS_W,
  localparam int FINE_W = SMP_W - CRS_W,
  localparam int SEG_N  = (1 << CRS_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SMP_W-1:0]  smp_l,
  input  logic [SMP_W-1:0]  smp_r,
  output logic [SEG_N-1:0]  seg_l,
  output logic [FINE_W-1:0] div_l,
  output logic              neg_l,
  output logic [SEG_N-1:0]  seg_r,
  output logic [FINE_W-1:0] div_r,
  output logic              neg_r
);
  localparam int NCH = 2;
  localparam int MID = mid_count(CRS_W);
  localparam logic [SEG_N-1:0] SEG_RST = SEG_N'((64'd1 << MID) - 64'd1);

  logic [SMP_W-1:0]  smp_a  [NCH];
  logic [CRS_W-1:0]  cnt_a  [NCH];
  logic [FINE_W-1:0] fine_a [NCH];
  logic              neg_a  [NCH];
  logic [SEG_N-1:0]  seg_a  [NCH];
  logic [SEG_N-1:0]  seg_q  [NCH];
  logic [FINE_W-1:0] div_q  [NCH];
  logic              neg_q  [NCH];

  assign smp_a[0] = smp_l;
  assign smp_a[1] = smp_r;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    seg_split #(.SMP_W(SMP_W), .CRS_W(CRS_W)) u_split (
      .smp  (smp_a[ch]),
      .cnt  (cnt_a[ch]),
      .fine (fine_a[ch]),
      .neg  (neg_a[ch])
    );

    seg_therm #(.CRS_W(CRS_W)) u_therm (
      .cnt (cnt_a[ch]),
      .seg (seg_a[ch])
    );

    // Output register: holds unless the shared strobe is high.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seg_q[ch] <= SEG_RST;
        div_q[ch] <= '0;
        neg_q[ch] <= 1'b0;
      end else if (load) begin
        seg_q[ch] <= seg_a[ch];
        div_q[ch] <= fine_a[ch];
        neg_q[ch] <= neg_a[ch];
      end
    end
  end

  assign seg_l = seg_q[0];
  assign div_l = div_q[0];
  assign neg_l = neg_q[0];
  assign seg_r = seg_q[1];
  assign div_r = div_q[1];
  assign neg_r = neg_q[1];
endmodule

// File: rtl/dac_seg_chk.sv
// Property checker attached to every instance of the decoder.
module dac_seg_chk #(
  parameter int SMP_W = 16,
  parameter int CRS_W = 5,
  localparam int FINE_W = SMP_W - CRS_W,
  localparam int SEG_N  = (1 << CRS_W) - 1,
  localparam int MID    = 1 << (CRS_W - 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic [SMP_W-1:0]  smp_l,
  input logic [SMP_W-1:0]  smp_r,
  input logic [SEG_N-1:0]  seg_l,
  input logic [FINE_W-1:0] div_l,
  input logic              neg_l,
  input logic [SEG_N-1:0]  seg_r,
  input logic [FINE_W-1:0] div_r,
  input logic              neg_r
);
  // R2: no gap in the enables, lowest bits first
  p_therm_l_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((seg_l & (seg_l + 1'b1)) == '0));
  p_therm_r_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((seg_r & (seg_r + 1'b1)) == '0));

  // R3: non-negative polarity keeps at least the centre count of segments
  p_pos_half_l_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !neg_l |-> (&seg_l[MID-1:0]));
  p_pos_half_r_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !neg_r |-> (&seg_r[MID-1:0]));

  // R4: mirrored polarity stays within the lower half, never empty
  p_neg_half_l_r4: assert property (@(posedge clk) disable iff (!rst_n)
    neg_l |-> (seg_l[SEG_N-1:MID] == '0 && seg_l[0]));
  p_neg_half_r_r4: assert property (@(posedge clk) disable iff (!rst_n)
    neg_r |-> (seg_r[SEG_N-1:MID] == '0 && seg_r[0]));

  // R8: no strobe, no change on either channel
  p_hold_l_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable({seg_l, div_l, neg_l}));
  p_hold_r_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable({seg_r, div_r, neg_r}));

  // R7: sample pins are only relevant on strobe edges; keep them referenced
  logic unused_ok;
  assign unused_ok = ^{smp_l, smp_r};
endmodule

bind seg_dac_decoder dac_seg_chk #(.SMP_W(SMP_W), .CRS_W(CRS_W)) u_chk (.*);

// File: tb/sim_seg_dac_decoder.sv
module sim_seg_dac_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [15:0] smp_l = '0;
  logic [15:0] smp_r = '0;
  logic [30:0] seg_l, seg_r;
  logic [10:0] div_l, div_r;
  logic        neg_l, neg_r;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [85:0] q_exp[$];
  string       q_tag[$];

  always #2ns clk = ~clk;   // 250 MHz

  seg_dac_decoder u0 (
    .clk(clk), .rst_n(rst_n), .load(load),
    .smp_l(smp_l), .smp_r(smp_r),
    .seg_l(seg_l), .div_l(div_l), .neg_l(neg_l),
    .seg_r(seg_r), .div_r(div_r), .neg_r(neg_r)
  );

  // Expected {segments, divider, polarity} from R3/R4 and R2.
  function automatic logic [42:0] model(input logic [15:0] s);
    int c;
    logic [15:0] m;
    logic [10:0] f;
    logic [30:0] t;
    if (!s[15]) begin
      c = 16 + int'(s[14:11]);
      f = s[10:0];
    end else begin
      m = ~s;
      c = 16 - int'(m[14:11]);
      f = 11'd2047 - m[10:0];
    end
    t = '0;
    for (int i = 0; i < 31; i++) t[i] = (i < c);
    return {t, f, s[15]};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [42:0] act, input logic [42:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: one strobe cycle per pair, expected values go to the scoreboard.
  task automatic apply(input logic [15:0] l, input logic [15:0] r,
                       input string tag);
    @(posedge clk); #1ns;
    smp_l = l;
    smp_r = r;
    load  = 1'b1;
    q_exp.push_back({model(l), model(r)});
    q_tag.push_back(tag);
    @(posedge clk); #1ns;
    load = 1'b0;
  endtask

  // Monitor: pops at the falling edge after a strobed rising edge,
  // otherwise compares against the values that must be held (R8).
  logic [85:0] cur;
  string       cur_tag;
  bit          have_cur = 1'b0;
  bit          armed = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (armed && q_exp.size() > 0) begin
          cur      = q_exp.pop_front();
          cur_tag  = q_tag.pop_front();
          have_cur = 1'b1;
          check({cur_tag, " R7"}, "left",  {seg_l, div_l, neg_l}, cur[85:43]);
          check({cur_tag, " R7"}, "right", {seg_r, div_r, neg_r}, cur[42:0]);
        end else if (have_cur) begin
          check("R8", "left hold",  {seg_l, div_l, neg_l}, cur[85:43]);
          check("R8", "right hold", {seg_r, div_r, neg_r}, cur[42:0]);
        end
        armed = (load === 1'b1);
      end
    end
  end

  initial begin
    #(200000 * 4ns);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [30:0] seg_a, seg_b;
    logic [15:0] lf;
    logic [42:0] mid;
    mid = {31'h0000FFFF, 11'd0, 1'b0};
    repeat (3) @(negedge clk);
    check("R1", "left in reset",  {seg_l, div_l, neg_l}, mid);
    check("R1", "right in reset", {seg_r, div_r, neg_r}, mid);
    @(posedge clk); #1ns;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "left after reset",  {seg_l, div_l, neg_l}, mid);
    check("R1", "right after reset", {seg_r, div_r, neg_r}, mid);
    cur = {mid, mid};
    have_cur = 1'b1;

    apply(16'd0,     16'd1,     "R3");
    apply(16'd2047,  16'd2048,  "R3");
    apply(16'd12345, 16'h3800,  "R3");
    apply(16'hFFFF,  16'hF800,  "R4");
    apply(16'hF7FF,  16'hCFC7,  "R4");
    apply(16'h7FFF,  16'h8000,  "R6");
    apply(16'h8000,  16'h7FFF,  "R6");

    // R5: -1 then 0 on left, 0 then -1 on right, coarse must not move
    apply(16'hFFFF, 16'h0000, "R5");
    @(negedge clk);
    seg_a = seg_l;
    seg_b = seg_r;
    apply(16'h0000, 16'hFFFF, "R5");
    @(negedge clk);
    check("R5", "left coarse -1 vs 0",  {12'd0, seg_l}, {12'd0, seg_a});
    check("R5", "right coarse 0 vs -1", {12'd0, seg_r}, {12'd0, seg_b});

    // R8: sample pins wander with the strobe low
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #1ns;
      smp_l = 16'h5555 ^ 16'(k * 4099);
      smp_r = 16'hAAAA + 16'(k * 777);
    end
    repeat (2) @(negedge clk);

    // R7: stereo pairs from a pseudo-random sequence
    lf = 16'hACE1;
    for (int k = 0; k < 60; k++) begin
      logic [15:0] a;
      a  = lf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      apply(a, lf ^ 16'h9D2C, a[15] ? "R4" : "R3");
    end

    repeat (4) @(negedge clk);
    if (q_exp.size() != 0) begin
      errs++;
      checks++;
      $display("FAIL R7 scoreboard left=%0d expected=0", q_exp.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule